// File: doc/BRIEF.md
# Gated Timer with Target Compare

A single 16-bit timer channel driven by a register port. Software selects how fast the count advances: a fixed division of the bus clock, or one step per horizontal blanking pulse. The count is compared against a target value, and a match or a wrap past all-ones can each raise an interrupt and set a sticky status flag.

Counting can be tied to a blanking signal. Horizontal or vertical blanking serves as a gate, and four gate behaviours are available. The gate can let counts through only while blanking is active. It can also restart the count from zero on the blanking start edge, on the end edge, or on both edges. A target that already lies behind the count is held off until the next wrap, so it cannot fire early.

The four registers are count, mode, target and a plain hold register. Writes take effect at the next clock edge. Reads are combinational on the address, and the upper 16 bits always read as zero.

Top module: `gated_timer`

## Requirements
- R1: After reset the count, mode and hold registers read 0 and the target reads 0xFFFF. Bits 31:16 of every read are 0. Address map: 0 count, 1 mode, 2 target, 3 hold.
- R2: Mode bits [1:0] select the count clock: 0 gives one step every 2 bus cycles, 1 every 32, 2 every 512, and 3 gives one step per rising edge of hblank_i. Counting requires the run bit (bit 7).
- R3: A mode write stores bits [9:0]. Status bits 10 (target) and 11 (overflow) are cleared only where the written value holds a 1, and are otherwise kept. Written bits above 11 are ignored.
- R4: With target interrupt enable (bit 8) set, a step that brings the count to the armed target sets bit 10 and pulses irq_o. If zero-return (bit 6) is also set, the count becomes count minus target and the compare stays armed.
- R5: When bit 8 is clear, a match sets no flag and raises no interrupt. When bit 6 is clear, the match still fires but the compare is disarmed until the next wrap.
- R6: A step from 0xFFFF wraps the count to 0 and re-arms the compare. It sets bit 11 and pulses irq_o only when overflow interrupt enable (bit 9) is set.
- R7: With the gate enabled (bit 2) and gate mode 0 (bits [5:4]), counting runs only between the rising and the falling edge of the gate signal. Bit 3 selects the gate signal: 0 for hblank_i, 1 for vblank_i.
- R8: Gate mode 1 clears the count, re-arms the compare and starts counting on the gate rising edge. Mode 2 does the same on the falling edge, and mode 3 on both edges.
- R9: A mode write that enables the gate clears the count and stops counting until a gate event. The gate is ignored when the gate source is hblank and the clock select is 3.
- R10: A count write keeps only the low 16 bits. If the new count is above the target, the compare is disarmed until the next wrap.
- R11: A target write with a value less than or equal to the current count disarms the compare until the next wrap.
- R12: irq_o is high for exactly one cycle per event. The status bits stay set until cleared by a mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hblank_i | input | 1 | Horizontal blanking pulse |
| vblank_i | input | 1 | Vertical blanking level |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The checker assumes that two count steps never fall in adjacent cycles. The smallest divider is 2, and hblank_i never rises on two consecutive cycles. The bench keeps every hblank pulse one cycle high with at least three cycles low, so the single-cycle interrupt rule can hold. It changes vblank_i only while no hblank pulse is in flight. It also lets edges settle for two cycles before it counts again, so gate events and count steps never share a cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MODE_W   = 12;
  localparam int P_GEN    = 2;
  localparam int P_GSRC   = 3;
  localparam int P_GM_LO  = 4;
  localparam int P_ZRET   = 6;
  localparam int P_RUN    = 7;
  localparam int P_TIE    = 8;
  localparam int P_OIE    = 9;
  localparam int P_TFLAG  = 10;
  localparam int P_OFLAG  = 11;

  typedef enum logic [1:0] {CS_DIV_A, CS_DIV_B, CS_DIV_C, CS_LINE} clk_sel_e;
  typedef enum logic [1:0] {GM_LEVEL, GM_START, GM_END, GM_BOTH} gate_mode_e;
  typedef enum logic [1:0] {A_COUNT, A_MODE, A_TARGET, A_HOLD} reg_addr_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 32,
  parameter int DIV_C = 512
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  clk_sel_e sel_i,
  input  logic     line_i,
  output logic     tick_o
);
  localparam int PW = $clog2(DIV_C);

  logic [PW-1:0] div_q;
  logic [PW-1:0] lim;
  logic          at_lim;

  always_comb begin
    unique case (sel_i)
      CS_DIV_A: lim = PW'(DIV_A - 1);
      CS_DIV_B: lim = PW'(DIV_B - 1);
      default:  lim = PW'(DIV_C - 1);
    endcase
  end

  // >= so a shorter divider selected mid-phase still ticks
  assign at_lim = div_q >= lim;
  assign tick_o = en_i & ((sel_i == CS_LINE) ? line_i : at_lim);

  // phase survives register writes; advances only while counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (en_i && sel_i != CS_LINE) div_q <= at_lim ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_gate.sv
module tmr_gate
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hblank_i,
  input  logic       vblank_i,
  input  logic       src_i,
  input  gate_mode_e mode_i,
  output logic       hb_rise_o,
  output logic       restart_o,
  output logic       open_o,
  output logic       close_o
);
  logic hb_q, vb_q;
  logic hb_fall, vb_rise, vb_fall, g_rise, g_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q <= 1'b0;
      vb_q <= 1'b0;
    end else begin
      hb_q <= hblank_i;
      vb_q <= vblank_i;
    end
  end

  assign hb_rise_o = hblank_i & ~hb_q;
  assign hb_fall   = ~hblank_i & hb_q;
  assign vb_rise   = vblank_i & ~vb_q;
  assign vb_fall   = ~vblank_i & vb_q;
  assign g_rise    = src_i ? vb_rise : hb_rise_o;
  assign g_fall    = src_i ? vb_fall : hb_fall;

  assign restart_o = ((mode_i == GM_START) & g_rise) |
                     ((mode_i == GM_END)   & g_fall) |
                     ((mode_i == GM_BOTH)  & (g_rise | g_fall));
  assign open_o    = (mode_i == GM_LEVEL) & g_rise;
  assign close_o   = (mode_i == GM_LEVEL) & g_fall;
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 32,
  parameter int DIV_C  = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hblank_i,
  input  logic              vblank_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt_q, tgt_q, hold_q;
  logic [MODE_W-1:0] mode_q;
  logic              armed_q, gate_run_q, irq_q;

  clk_sel_e   clk_sel;
  gate_mode_e gmode;
  logic gate_used, nm_used, counting, cnt_tick, hb_rise;
  logic g_restart, g_open, g_close, gate_rst;
  logic wr_cnt, wr_mode, wr_tgt, wr_hold, blk_wr;
  logic [CNT_W:0] cnt_inc;
  logic wrap, hit;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign clk_sel   = clk_sel_e'(mode_q[1:0]);
  assign gmode     = gate_mode_e'(mode_q[P_GM_LO+1:P_GM_LO]);
  assign gate_used = mode_q[P_GEN] & ~(~mode_q[P_GSRC] & (clk_sel == CS_LINE));
  assign nm_used   = wdata_i[P_GEN] & ~(~wdata_i[P_GSRC] & (wdata_i[1:0] == 2'd3));
  assign counting  = mode_q[P_RUN] & (~gate_used | gate_run_q);

  assign wr_cnt  = wr_en_i & (reg_addr_e'(addr_i) == A_COUNT);
  assign wr_mode = wr_en_i & (reg_addr_e'(addr_i) == A_MODE);
  assign wr_tgt  = wr_en_i & (reg_addr_e'(addr_i) == A_TARGET);
  assign wr_hold = wr_en_i & (reg_addr_e'(addr_i) == A_HOLD);
  assign blk_wr  = wr_cnt | wr_mode | wr_tgt;

  tmr_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (counting),
    .sel_i (clk_sel),
    .line_i(hb_rise),
    .tick_o(cnt_tick)
  );

  tmr_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hblank_i (hblank_i),
    .vblank_i (vblank_i),
    .src_i    (mode_q[P_GSRC]),
    .mode_i   (gmode),
    .hb_rise_o(hb_rise),
    .restart_o(g_restart),
    .open_o   (g_open),
    .close_o  (g_close)
  );

  assign gate_rst = gate_used & g_restart;
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign wrap     = &cnt_q;
  assign hit      = armed_q & ~wrap & (cnt_inc[CNT_W-1:0] >= tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      tgt_q      <= '1;
      hold_q     <= '0;
      mode_q     <= '0;
      armed_q    <= 1'b1;
      gate_run_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_hold) hold_q <= wdata_i[CNT_W-1:0];
      if (wr_mode) begin
        mode_q[P_OFLAG:P_TFLAG] <= mode_q[P_OFLAG:P_TFLAG] & ~wdata_i[P_OFLAG:P_TFLAG];
        mode_q[P_TFLAG-1:0]     <= wdata_i[P_TFLAG-1:0];
        if (nm_used) begin
          cnt_q      <= '0;
          gate_run_q <= 1'b0;
        end
      end else if (wr_cnt) begin
        cnt_q   <= wdata_i[CNT_W-1:0];
        armed_q <= !(wdata_i[CNT_W-1:0] > tgt_q);
      end else if (wr_tgt) begin
        tgt_q   <= wdata_i[CNT_W-1:0];
        armed_q <= wdata_i[CNT_W-1:0] > cnt_q;
      end else if (gate_rst) begin
        cnt_q      <= '0;
        armed_q    <= 1'b1;
        gate_run_q <= 1'b1;
      end else begin
        if (gate_used && g_open)  gate_run_q <= 1'b1;
        if (gate_used && g_close) gate_run_q <= 1'b0;
        if (cnt_tick) begin
          if (wrap) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            if (mode_q[P_OIE]) begin
              mode_q[P_OFLAG] <= 1'b1;
              irq_q           <= 1'b1;
            end
          end else if (hit) begin
            if (mode_q[P_TIE]) begin
              mode_q[P_TFLAG] <= 1'b1;
              irq_q           <= 1'b1;
            end
            if (mode_q[P_TIE] && mode_q[P_ZRET])
              cnt_q <= CNT_W'(cnt_inc - {1'b0, tgt_q});
            else begin
              cnt_q   <= cnt_inc[CNT_W-1:0];
              armed_q <= 1'b0;
            end
          end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
          end
        end
      end
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_COUNT:  rdata_o = DATA_W'(cnt_q);
      A_MODE:   rdata_o = DATA_W'(mode_q);
      A_TARGET: rdata_o = DATA_W'(tgt_q);
      default:  rdata_o = DATA_W'(hold_q);
    endcase
  end
endmodule

// File: rtl/gated_timer_chk.sv
module gated_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             cnt_tick,
  input logic             gate_rst,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [11:0]      mode_q
);
  logic mode_wr;
  assign mode_wr = wr_en_i && addr_i == 2'd1;

  // R12
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R6
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_tick && (&cnt_q) && !wr_en_i) |=> cnt_q == '0);

  // R3
  tflag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[10] && !mode_wr) |=> mode_q[10]);

  // R3
  oflag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[11] && !mode_wr) |=> mode_q[11]);

  // R4
  flag_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q[10]) |-> irq_o);

  // R2
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_tick && !wr_en_i && !gate_rst) |=> $stable(cnt_q));

  // R9
  gate_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr && wdata_i[2] && wdata_i[3]) |=> cnt_q == '0);
endmodule

bind gated_timer gated_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .cnt_tick(cnt_tick),
  .gate_rst(gate_rst),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .cnt_q   (cnt_q),
  .mode_q  (mode_q)
);

// File: tb/gated_timer_tb_top.sv
module gated_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb = 1'b0, vb = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, fails = 0, irq_cnt = 0, irq_hi = 0;
  logic irq_prev = 1'b0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  exp_t it;

  always #5 clk = ~clk;

  gated_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hblank_i(hb), .vblank_i(vb),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: scoreboard reads and irq activity
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (irq) irq_hi++;
      if (irq && !irq_prev) irq_cnt++;
      irq_prev = irq;
    end
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s: addr %0d read 0x%08h expected 0x%08h", it.tag, addr, rdata, it.exp);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(logic [31:0] e, string tag);
    exp_t x;
    x.exp = e; x.tag = tag;
    sb_q.push_back(x);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] e, string tag);
    @(posedge clk); #1;
    addr = a;
    push_exp(e, tag);
    @(negedge clk); #1;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 hb = 1'b1;
      @(posedge clk); #1 hb = 1'b0;
      repeat (3) @(posedge clk);
    end
  endtask

  task automatic set_vb(logic v);
    @(posedge clk); #1 vb = v;
    repeat (2) @(posedge clk);
  endtask

  task automatic measure(logic [31:0] mode_val, int div, int k, string tag);
    logic [31:0] v;
    wr(2'd0, 32'd0);
    wr(2'd1, mode_val);
    @(posedge clk); #1 addr = 2'd0;
    @(negedge clk);
    v = rdata;
    do @(negedge clk); while (rdata == v);
    v = rdata;
    repeat (div * k - 1) @(negedge clk);
    #1 push_exp(v + k, tag);
    @(negedge clk); #1;
    wr(2'd1, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values and zero upper half
    rd(2'd0, 32'h0, "R1");
    rd(2'd1, 32'h0, "R1");
    rd(2'd2, 32'h0000_FFFF, "R1");
    rd(2'd3, 32'h0, "R1");
    wr(2'd3, 32'hABCD_1234);
    rd(2'd3, 32'h0000_1234, "R1");
    // R2 line clock
    wr(2'd1, 32'h83);
    pulse(5);
    rd(2'd0, 32'd5, "R2");
    // R2 bus-clock dividers
    wr(2'd1, 32'h0);
    measure(32'h80, 2, 10, "R2");
    measure(32'h81, 32, 3, "R2");
    measure(32'h82, 512, 2, "R2");
    // R4 match with zero-return
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd3);
    wr(2'd1, 32'h1C3);
    pulse(3);
    rd(2'd0, 32'd0, "R4");
    rd(2'd1, 32'h5C3, "R4");
    chk(irq_cnt, 1, "R4");
    pulse(3);
    rd(2'd0, 32'd0, "R4");
    chk(irq_cnt, 2, "R4");
    // R3 flag clearing rules
    wr(2'd1, 32'h1C3);
    rd(2'd1, 32'h5C3, "R3");
    wr(2'd1, 32'hF000_0DC3);
    rd(2'd1, 32'h1C3, "R3");
    // R5 no zero-return: one match only
    wr(2'd1, 32'h183);
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd2);
    pulse(2);
    chk(irq_cnt, 3, "R5");
    pulse(3);
    rd(2'd0, 32'd5, "R5");
    chk(irq_cnt, 3, "R5");
    // R5 no target interrupt enable
    wr(2'd1, 32'h483);
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd2);
    pulse(4);
    rd(2'd1, 32'h83, "R5");
    chk(irq_cnt, 3, "R5");
    // R10 count write width and disarm; R6 wrap re-arms without overflow irq
    wr(2'd1, 32'h103);
    wr(2'd2, 32'h10);
    wr(2'd0, 32'h1FFFE);
    rd(2'd0, 32'h0000_FFFE, "R10");
    wr(2'd1, 32'h183);
    pulse(2);
    rd(2'd0, 32'd0, "R6");
    rd(2'd1, 32'h183, "R10");
    chk(irq_cnt, 3, "R6");
    pulse(16);
    rd(2'd1, 32'h583, "R6");
    chk(irq_cnt, 4, "R6");
    // R11 target at or below count is disarmed
    wr(2'd1, 32'hD03);
    wr(2'd0, 32'h30);
    wr(2'd2, 32'h30);
    wr(2'd1, 32'h183);
    pulse(1);
    rd(2'd1, 32'h183, "R11");
    chk(irq_cnt, 4, "R11");
    wr(2'd1, 32'h103);
    wr(2'd2, 32'h32);
    wr(2'd1, 32'h183);
    pulse(1);
    rd(2'd1, 32'h583, "R11");
    chk(irq_cnt, 5, "R11");
    // R6 overflow with interrupt
    wr(2'd1, 32'hF03);
    wr(2'd0, 32'hFFFE);
    wr(2'd1, 32'h383);
    pulse(2);
    rd(2'd0, 32'd0, "R6");
    rd(2'd1, 32'hB83, "R6");
    chk(irq_cnt, 6, "R6");
    // R9 gate enable clears; R7 level gate on vblank
    wr(2'd1, 32'hC83);
    wr(2'd0, 32'd5);
    rd(2'd0, 32'd5, "R9");
    wr(2'd1, 32'h8F);
    rd(2'd0, 32'd0, "R9");
    pulse(2);
    rd(2'd0, 32'd0, "R7");
    set_vb(1'b1);
    pulse(3);
    rd(2'd0, 32'd3, "R7");
    set_vb(1'b0);
    pulse(2);
    rd(2'd0, 32'd3, "R7");
    // R8 restart on rising edge
    wr(2'd1, 32'h9F);
    pulse(2);
    rd(2'd0, 32'd0, "R8");
    set_vb(1'b1);
    pulse(4);
    rd(2'd0, 32'd4, "R8");
    set_vb(1'b0);
    pulse(1);
    rd(2'd0, 32'd5, "R8");
    set_vb(1'b1);
    pulse(1);
    rd(2'd0, 32'd1, "R8");
    set_vb(1'b0);
    // R8 restart on falling edge
    wr(2'd1, 32'hAF);
    set_vb(1'b1);
    pulse(2);
    rd(2'd0, 32'd0, "R8");
    set_vb(1'b0);
    pulse(3);
    rd(2'd0, 32'd3, "R8");
    // R8 restart on both edges
    wr(2'd1, 32'hBF);
    set_vb(1'b1);
    pulse(2);
    rd(2'd0, 32'd2, "R8");
    set_vb(1'b0);
    rd(2'd0, 32'd0, "R8");
    pulse(1);
    rd(2'd0, 32'd1, "R8");
    // R9 gate ignored for hblank source with hblank clock
    wr(2'd1, 32'h83);
    wr(2'd0, 32'd7);
    wr(2'd1, 32'h87);
    rd(2'd0, 32'd7, "R9");
    pulse(2);
    rd(2'd0, 32'd9, "R9");
    // R12 single-cycle interrupt pulses
    chk(irq_hi, irq_cnt, "R12");
    chk(irq_cnt, 6, "R12");
    repeat (2) @(posedge clk);
    report();
  end
endmodule